// File: doc/BRIEF.md
# Timer clock select prescaler

This block generates the count-enable tick for a timer counter. A 3-bit select code picks the source. One code stops the timer. Five codes take a divided system clock from a shared free-running 10-bit prescale counter. Two codes count edges of an external input pin, one code for falling edges and one for rising edges. The timer counter itself consumes `tick_o` as a one-cycle enable.

The external input is sampled whatever the direction of its pad. Software can therefore toggle its own output register to clock the timer. The pin passes through a two-flop synchronizer, and the synchronized level is also brought out. A synchronous clear input restarts the prescale counter so that the next divided tick comes a full period later.

Top module: `tmr_clk_sel`

## Requirements
- R1: While `rst_ni` is low, `tick_o` and `ext_sync_o` are 0, the prescale counter is 0 and the synchronizer holds low.
- R2: Select code 0 (000) stops the timer: `tick_o` stays 0.
- R3: Select code 1 (001) divides by 1: `tick_o` is 1 in every cycle that follows a clock edge at which code 1 was selected. The clear input does not affect this code.
- R4: Select codes 2, 3, 4 and 5 divide by 8, 64, 256 and 1024, using the low 3, 6, 8 and 10 bits of the shared prescale counter. The counter increments every clock. `tick_o` is 1 for exactly the one cycle after an edge at which those low bits were all ones.
- R5: Select code 6 (110) gives one one-cycle tick per falling edge of `ext_i`. The tick is high in the cycle after the third clock edge that follows the change of the pin.
- R6: Select code 7 (111) gives one one-cycle tick per rising edge of `ext_i`, with the same latency as R5.
- R7: `ext_sync_o` equals the value of `ext_i` sampled two clock edges earlier, whatever the select code.
- R8: `pre_clr_i` high at a clock edge sets the prescale counter to 0 and suppresses any divided tick (codes 2 to 5) at that edge. The next divide-by-N tick follows exactly N edges later if the clear is not repeated.
- R9: A new select code takes effect at the first clock edge at which it is present, and no extra tick is produced by the change itself. A divided tick appears at the switching edge only when the counter's low bits happen to be all ones there. An external tick appears there only when the new edge type is detected at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 3 | Clock-select code |
| pre_clr_i | input | 1 | Synchronous prescale counter clear |
| ext_i | input | 1 | External count pin, asynchronous |
| tick_o | output | 1 | One-cycle count-enable tick |
| ext_sync_o | output | 1 | Synchronized level of `ext_i` |

## Verification
A divided tick or a stop/divide-by-1 decision is due one edge after the edge that sees the select code and counter value. An external-edge tick is due three edges after the pin changes. `ext_sync_o` follows the pin two edges later. The bench drives every input just after the falling clock edge. In the same step it advances its own model of the prescale counter and pin pipeline and computes the value `tick_o` must show after the next rising edge. It compares that value at the following falling edge, so every result is sampled in the cycle it is due, with no tolerance window.

// File: rtl/tmr_clk_pkg.sv
package tmr_clk_pkg;
  localparam int PRE_W  = 10;
  localparam int N_TAPS = 4;

  typedef enum logic [2:0] {
    CS_STOP     = 3'd0,
    CS_DIV1     = 3'd1,
    CS_DIV8     = 3'd2,
    CS_DIV64    = 3'd3,
    CS_DIV256   = 3'd4,
    CS_DIV1024  = 3'd5,
    CS_EXT_FALL = 3'd6,
    CS_EXT_RISE = 3'd7
  } cs_e;

  // low counter bits that must be all ones for tap i
  function automatic int tap_shift(input int i);
    case (i)
      0:       return 3;
      1:       return 6;
      2:       return 8;
      default: return 10;
    endcase
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_clk_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  output logic [N_TAPS-1:0] tap_o
);
  logic [PRE_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  for (genvar i = 0; i < N_TAPS; i++) begin : g_tap
    localparam int SH = tap_shift(i);
    assign tap_o[i] = &cnt_q[SH-1:0];
  end

  // R8
  clr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/tmr_ext_edge.sv
module tmr_ext_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_i,
  output logic sync_o,
  output logic rise_o,
  output logic fall_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], ext_i};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign sync_o = sync_q[SYNC_STAGES-1];
  assign rise_o =  sync_o & ~prev_q;
  assign fall_o = ~sync_o &  prev_q;

  // checker-only: edges seen since reset, saturating
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              age_q <= '0;
    else if (age_q != 2'd3)   age_q <= age_q + 1'b1;
  end

  // R7
  sync_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd2) |-> (sync_o == $past(ext_i, 2)));
endmodule

// File: rtl/tmr_tick_sel.sv
module tmr_tick_sel
  import tmr_clk_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        sel_i,
  input  logic              clr_i,
  input  logic [N_TAPS-1:0] tap_i,
  input  logic              rise_i,
  input  logic              fall_i,
  output logic              tick_o
);
  cs_e        sel;
  logic [1:0] tap_idx;
  logic       tick_d;

  assign sel     = cs_e'(sel_i);
  assign tap_idx = 2'(sel_i - 3'd2);

  always_comb begin
    unique case (sel)
      CS_STOP:     tick_d = 1'b0;
      CS_DIV1:     tick_d = 1'b1;
      CS_EXT_FALL: tick_d = fall_i;
      CS_EXT_RISE: tick_d = rise_i;
      default:     tick_d = ~clr_i & tap_i[tap_idx];
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tick_o <= 1'b0;
    else         tick_o <= tick_d;
  end

  // R2
  stop_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 3'd0) |=> !tick_o);

  // R3
  div1_every_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 3'd1) |=> tick_o);

  // R4
  div_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && sel_i >= 3'd2 && sel_i <= 3'd5 && sel_i == $past(sel_i)) |=> !tick_o);
endmodule

// File: rtl/tmr_clk_sel.sv
module tmr_clk_sel
  import tmr_clk_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] sel_i,
  input  logic       pre_clr_i,
  input  logic       ext_i,
  output logic       tick_o,
  output logic       ext_sync_o
);
  logic [N_TAPS-1:0] tap;
  logic              rise, fall;

  tmr_prescaler u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (pre_clr_i),
    .tap_o  (tap)
  );

  tmr_ext_edge #(.SYNC_STAGES(2)) u_ext (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ext_i  (ext_i),
    .sync_o (ext_sync_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  tmr_tick_sel u_sel (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (sel_i),
    .clr_i  (pre_clr_i),
    .tap_i  (tap),
    .rise_i (rise),
    .fall_i (fall),
    .tick_o (tick_o)
  );

  // R6
  rise_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 3'd7 && rise) |=> tick_o);

  // R5
  fall_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 3'd6 && fall) |=> tick_o);
endmodule

// File: tb/sim_tmr_clk_sel.sv
module sim_tmr_clk_sel;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] sel_i = 3'd0;
  logic       pre_clr_i = 1'b0;
  logic       ext_i = 1'b0;
  logic       tick_o, ext_sync_o;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  // model state
  int unsigned m_cnt = 0;
  bit m_s1 = 0, m_s2 = 0, m_s3 = 0;
  bit exp_tick = 0;
  string exp_req = "R1";
  logic [2:0] last_sel = 3'd0;

  always #5 clk_i = ~clk_i;

  tmr_clk_sel u0 (.*);

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: actual cycle %0d expected < 150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  function automatic string req_of(input logic [2:0] s, input bit clr, input bit chg);
    if (chg) return "R9";
    if (clr && s >= 3'd2 && s <= 3'd5) return "R8";
    case (s)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd6: return "R5";
      3'd7: return "R6";
      default: return "R4";
    endcase
  endfunction

  function automatic bit next_tick(input logic [2:0] s, input bit clr);
    int unsigned mask;
    case (s)
      3'd0: return 0;
      3'd1: return 1;
      3'd6: return !m_s2 && m_s3;
      3'd7: return m_s2 && !m_s3;
      default: begin
        mask = (s == 3'd2) ? 7 : (s == 3'd3) ? 63 : (s == 3'd4) ? 255 : 1023;
        return !clr && ((m_cnt & mask) == mask);
      end
    endcase
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // apply inputs now (just after a falling edge), advance model, check after next edge
  task automatic step(input logic [2:0] s, input bit clr, input bit e);
    sel_i = s; pre_clr_i = clr; ext_i = e;
    exp_tick = next_tick(s, clr);
    exp_req  = req_of(s, clr, s != last_sel);
    last_sel = s;
    m_cnt = clr ? 0 : ((m_cnt + 1) % 1024);
    m_s3 = m_s2; m_s2 = m_s1; m_s1 = e;
    @(negedge clk_i);
    chk(exp_req, tick_o, exp_tick);
    chk("R7", ext_sync_o, m_s2);
  endtask

  task automatic run(input logic [2:0] s, input int n);
    for (int i = 0; i < n; i++) step(s, 0, ext_i);
  endtask

  // toggle the pin, holding each level 2..5 clocks
  task automatic run_ext(input logic [2:0] s, input int toggles);
    for (int t = 0; t < toggles; t++) begin
      int hold = 2 + ($urandom % 4);
      bit e = !ext_i;
      for (int h = 0; h < hold; h++) step(s, 0, e);
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    ext_i = 1'b1;  // pin high during reset must not reach outputs
    repeat (3) @(negedge clk_i);
    chk("R1", tick_o, 1'b0);
    chk("R1", ext_sync_o, 1'b0);
    ext_i = 1'b0;
    rst_ni = 1'b1;

    run(3'd0, 100);                    // R2
    run(3'd1, 40);                     // R3
    run(3'd2, 100);                    // R4 /8
    run(3'd3, 200);                    // R4 /64
    run(3'd4, 600);                    // R4 /256
    run(3'd5, 2200);                   // R4 /1024
    step(3'd2, 1, 0);                  // R8 clear then full period
    run(3'd2, 30);
    for (int i = 0; i < 5; i++) begin step(3'd3, 1, 0); run(3'd3, 70); end
    step(3'd1, 1, 0);                  // R3 ignores clear
    run_ext(3'd7, 40);                 // R6
    run_ext(3'd6, 40);                 // R5
    run_ext(3'd0, 10);                 // R2 with pin activity
    // R9 select changes mixed with random clears and pin traffic
    for (int k = 0; k < 400; k++) begin
      logic [2:0] s = 3'($urandom % 8);
      int len = 1 + ($urandom % 40);
      for (int j = 0; j < len; j++) begin
        bit clr = ($urandom % 50) == 0;
        bit e = (($urandom % 3) == 0) ? !ext_i : ext_i;
        step(s, clr, e);
      end
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule